// File: doc/BRIEF.md
# Two-way set-associative write-back cache with LRU replacement

The block sits between a processor-side request stream and a word-wide memory port and holds recently used blocks of a small, word-addressed space. An address holds, from most to least significant bit, a tag, a set index and a word offset. The set index picks one set. Both ways of that set have their tags compared with the request at the same time, and a valid match in either way is a hit. On a miss a victim way is chosen. An invalid way is taken first, way A before way B. When both ways are valid, the way that the set's least-recently-used bit points at is taken. A dirty victim is copied out to memory word by word. The missing block is then read in, and the request completes against the refilled line. Writes allocate on a miss and mark the line dirty. Memory is updated only when a dirty line is evicted.

All data-carrying channels use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so one access is in flight at a time. A response stays valid, with its data and hit flag frozen, until `rsp_ready` is seen high. The memory request channel works the same way: the address, the direction and the write data stay frozen while `mem_ready` is low. A block refill is one read request at the block's first word. Memory then answers with one beat per word on `mem_rvalid`, lowest offset first. The block always accepts these beats, so there is no back-pressure on them. A write-back is one write request per word, lowest offset first.

Top module: `lru2way_cache`

## Requirements
- R1: After reset every line is invalid and each set's LRU bit names way A as least recent. The first access to any address misses. `req_ready` is 1, and `rsp_valid` and `mem_valid` are 0.
- R2: The address is {tag[5:2], set[1], word[0]} at default widths. Both ways of the indexed set are compared in parallel. `rsp_hit`=1 exactly when one of them is valid with an equal tag.
- R3: On a miss the victim is the invalid way of the set, way A before way B. When both ways are valid, the victim is the least-recently-used way.
- R4: Every completed access, hit or miss, makes the way it used most recent in its set and the other way least recent.
- R5: A block is only ever placed in the set its index bits select, so traffic in one set never evicts a line of another set.
- R6: A read returns the last value written to that address, or the memory's initial value if none was written. A write returns the written value in `rsp_rdata`.
- R7: A write marks its line dirty, and a refill leaves the line clean. Evicting a dirty line issues one memory write per word, offsets in rising order, carrying the line's data. These writes are issued back to back and before the refill read. Evicting a clean line issues no write.
- R8: A miss issues exactly one memory read, with the word offset 0. The refill takes one `mem_rvalid` beat per word, offset 0 first. A hit issues no memory request.
- R9: `req_ready` is high only when idle. A pending response keeps `rsp_valid`, `rsp_rdata` and `rsp_hit` stable until `rsp_ready`. A pending memory request keeps its address, direction and write data stable until `mem_ready`.
- R10: The accesses (tag/set/word) 1000/0/0, 1000/1/1, 0101/1/0, 1000/0/1, 1011/1/1, 0101/1/0 from reset give miss, miss, miss, hit, miss, hit, and tag 1011 evicts tag 1000 from set 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | TAG_W+IDX_W+OFF_W | Word address {tag, set, word} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_rdata | output | DATA_W | Read data, or the written value for a write |
| rsp_hit | output | 1 | 1 when the access hit without a refill |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request |
| mem_write | output | 1 | 1 = write-back beat, 0 = refill read |
| mem_addr | output | TAG_W+IDX_W+OFF_W | Word address of the beat or block |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rvalid | input | 1 | Refill beat present, always accepted |
| mem_rdata | input | DATA_W | Refill beat data |

## Verification
The bench builds the block with its defaults: a 4-bit tag, one set bit, one word bit and 8-bit data. At these widths there are only two sets and a 64-word space, so a short run reaches the interesting cases often. Random tags are drawn from a pool of six. This keeps both ways of each set full, lets LRU ordering decide most victims, and makes dirty evictions frequent. Random back-pressure on the memory and response channels, and gaps between refill beats, exercise every wait state of the sequencer.

// File: rtl/lru2_pkg.sv
package lru2_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_RDREQ,
    ST_RDATA,
    ST_RESP
  } cstate_e;
endpackage

// File: rtl/lru2_line_store.sv
module lru2_line_store
  import lru2_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 1,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [IDX_W-1:0]                   set_i,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]     tag_o,
  output logic [NUM_WAYS-1:0]                valid_o,
  output logic [NUM_WAYS-1:0]                dirty_o,
  input  logic                               rd_way_i,
  input  logic [OFF_W-1:0]                   rd_word_i,
  output logic [DATA_W-1:0]                  rd_data_o,
  input  logic                               fill_i,
  input  logic                               fill_way_i,
  input  logic [TAG_W-1:0]                   fill_tag_i,
  input  logic                               dirty_set_i,
  input  logic                               dirty_way_i,
  input  logic                               we_i,
  input  logic                               we_way_i,
  input  logic [OFF_W-1:0]                   we_word_i,
  input  logic [DATA_W-1:0]                  we_data_i
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [TAG_W-1:0]  tag_q  [SETS][NUM_WAYS];
  logic [DATA_W-1:0] data_q [SETS][NUM_WAYS][WORDS];
  logic [SETS-1:0][NUM_WAYS-1:0] vld_q;
  logic [SETS-1:0][NUM_WAYS-1:0] drt_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way_out
    assign tag_o[w]   = tag_q[set_i][w];
    assign valid_o[w] = vld_q[set_i][w];
    assign dirty_o[w] = drt_q[set_i][w];
  end

  assign rd_data_o = data_q[set_i][rd_way_i][rd_word_i];

  // state bits: cleared at reset, set on fill, dirty on a write
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      drt_q <= '0;
    end else begin
      if (fill_i) begin
        vld_q[set_i][fill_way_i] <= 1'b1;
        drt_q[set_i][fill_way_i] <= 1'b0;
      end
      if (dirty_set_i) begin
        drt_q[set_i][dirty_way_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_i) begin
      tag_q[set_i][fill_way_i] <= fill_tag_i;
    end
    if (we_i) begin
      data_q[set_i][we_way_i][we_word_i] <= we_data_i;
    end
  end
endmodule

// File: rtl/lru2_way_match.sv
module lru2_way_match
  import lru2_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]               tag_i,
  output logic [NUM_WAYS-1:0]            hit_vec_o,
  output logic                           hit_o,
  output logic                           hit_way_o
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o     = |hit_vec_o;
  assign hit_way_o = hit_vec_o[1];
endmodule

// File: rtl/lru2_repl.sv
module lru2_repl
  import lru2_pkg::*;
#(
  parameter int IDX_W = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    set_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic                touch_i,
  input  logic                touch_way_i,
  output logic                victim_o
);
  localparam int SETS = 1 << IDX_W;

  // per set: index of the least recently used way
  logic [SETS-1:0] lru_q;

  always_comb begin
    if (!valid_i[0])      victim_o = 1'b0;
    else if (!valid_i[1]) victim_o = 1'b1;
    else                  victim_o = lru_q[set_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (touch_i) begin
      lru_q[set_i] <= ~touch_way_i;
    end
  end
endmodule

// File: rtl/lru2way_cache.sv
module lru2way_cache
  import lru2_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 1,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  cstate_e           state_q;
  logic              r_write;
  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_set;
  logic [OFF_W-1:0]  r_off;
  logic [DATA_W-1:0] r_wdata;
  logic              missed_q;
  logic              vict_q;
  logic [OFF_W-1:0]  beat_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [NUM_WAYS-1:0][TAG_W-1:0] set_tags;
  logic [NUM_WAYS-1:0] set_valid, set_dirty, hit_vec;
  logic hit, hit_way, victim;
  logic rd_way;
  logic [OFF_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_data;
  logic fill, dirty_set, we, we_way, touch;
  logic [OFF_W-1:0] we_word;
  logic [DATA_W-1:0] we_data;

  lru2_line_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .set_i       (r_set),
    .tag_o       (set_tags),
    .valid_o     (set_valid),
    .dirty_o     (set_dirty),
    .rd_way_i    (rd_way),
    .rd_word_i   (rd_word),
    .rd_data_o   (rd_data),
    .fill_i      (fill),
    .fill_way_i  (vict_q),
    .fill_tag_i  (r_tag),
    .dirty_set_i (dirty_set),
    .dirty_way_i (hit_way),
    .we_i        (we),
    .we_way_i    (we_way),
    .we_word_i   (we_word),
    .we_data_i   (we_data)
  );

  lru2_way_match #(.TAG_W(TAG_W)) u_match (
    .tags_i    (set_tags),
    .valid_i   (set_valid),
    .tag_i     (r_tag),
    .hit_vec_o (hit_vec),
    .hit_o     (hit),
    .hit_way_o (hit_way)
  );

  lru2_repl #(.IDX_W(IDX_W)) u_repl (
    .clk         (clk),
    .rst         (rst),
    .set_i       (r_set),
    .valid_i     (set_valid),
    .touch_i     (touch),
    .touch_way_i (hit_way),
    .victim_o    (victim)
  );

  // datapath steering per state
  always_comb begin
    fill      = 1'b0;
    dirty_set = 1'b0;
    we        = 1'b0;
    we_way    = hit_way;
    we_word   = r_off;
    we_data   = r_wdata;
    touch     = 1'b0;
    rd_way    = hit_way;
    rd_word   = r_off;
    case (state_q)
      ST_LOOK: begin
        if (hit) begin
          touch = 1'b1;
          if (r_write) begin
            we        = 1'b1;
            dirty_set = 1'b1;
          end
        end
      end
      ST_WB: begin
        rd_way  = vict_q;
        rd_word = beat_q;
      end
      ST_RDATA: begin
        if (mem_rvalid) begin
          we      = 1'b1;
          we_way  = vict_q;
          we_word = beat_q;
          we_data = mem_rdata;
          fill    = (beat_q == LAST_BEAT);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      r_write    <= 1'b0;
      r_tag      <= '0;
      r_set      <= '0;
      r_off      <= '0;
      r_wdata    <= '0;
      missed_q   <= 1'b0;
      vict_q     <= 1'b0;
      beat_q     <= '0;
      rsp_data_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            r_write  <= req_write;
            r_tag    <= req_addr[ADDR_W-1 -: TAG_W];
            r_set    <= req_addr[OFF_W +: IDX_W];
            r_off    <= req_addr[OFF_W-1:0];
            r_wdata  <= req_wdata;
            missed_q <= 1'b0;
            state_q  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_data_q <= r_write ? r_wdata : rd_data;
            state_q    <= ST_RESP;
          end else begin
            missed_q <= 1'b1;
            vict_q   <= victim;
            beat_q   <= '0;
            state_q  <= (set_valid[victim] && set_dirty[victim]) ? ST_WB : ST_RDREQ;
          end
        end
        ST_WB: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_RDREQ;
          end
        end
        ST_RDREQ: begin
          if (mem_ready) begin
            beat_q  <= '0;
            state_q <= ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (mem_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_LOOK;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_hit   = ~missed_q;
  assign mem_valid = (state_q == ST_WB) || (state_q == ST_RDREQ);
  assign mem_write = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? {set_tags[vict_q], r_set, beat_q}
                                        : {r_tag, r_set, {OFF_W{1'b0}}};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/lru2way_cache_chk.sv
module lru2way_cache_chk #(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_hit,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [1:0]        hit_vec
);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !rsp_valid && !mem_valid));

  a_r9_idle_exclusive: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_valid));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit)));

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  a_r9_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write && !mem_ready) |=> $stable(mem_wdata));

  a_r8_read_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_write) |-> (mem_addr[OFF_W-1:0] == '0));

  a_r7_wb_consecutive: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_write && (mem_addr[OFF_W-1:0] != LAST_OFF)) |=>
    (mem_valid && mem_write &&
     (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])) &&
     (mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1)));

  a_r7_wb_then_refill: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_write && (mem_addr[OFF_W-1:0] == LAST_OFF)) |=>
    (mem_valid && !mem_write));

  a_r5_single_way_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

bind lru2way_cache lru2way_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_hit   (rsp_hit),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .hit_vec   (hit_vec)
);

// File: tb/tb_lru2way_cache.sv
`timescale 1ns/1ps
module tb_lru2way_cache;
  localparam int TAG_W  = 4;
  localparam int IDX_W  = 1;
  localparam int OFF_W  = 1;
  localparam int DATA_W = 8;
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int SPACE  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_rdata;
  logic mem_valid, mem_write;
  logic mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  lru2way_cache #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // memory model and traffic counters
  logic [DATA_W-1:0] mem [SPACE];
  logic [DATA_W-1:0] refv [SPACE];
  int wb_beats = 0, rd_reqs = 0, wb_errs = 0, rd_errs = 0;
  int wb_next = 0;
  bit txn_rd_seen = 0;
  int rd_left = 0, rd_base = 0, rd_idx = 0;
  bit rd_fresh = 0;

  // requirement-level model of the line state
  bit              m_vld [SETS][2];
  bit              m_drt [SETS][2];
  logic [TAG_W-1:0] m_tag [SETS][2];
  bit              m_lru [SETS];

  function automatic logic [DATA_W-1:0] init_word(int a);
    return DATA_W'(a * 37 + 11);
  endfunction

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                              output bit eh, output bit ewb, output logic [DATA_W-1:0] ed);
    int s;
    int way;
    logic [TAG_W-1:0] t;
    s = int'(a[OFF_W +: IDX_W]);
    t = a[ADDR_W-1 -: TAG_W];
    eh = 0; ewb = 0; way = 0;
    for (int w = 0; w < 2; w++) begin
      if (m_vld[s][w] && m_tag[s][w] == t) begin eh = 1; way = w; end
    end
    if (!eh) begin
      if (!m_vld[s][0])      way = 0;
      else if (!m_vld[s][1]) way = 1;
      else                   way = int'(m_lru[s]);
      ewb = m_vld[s][way] && m_drt[s][way];
      m_vld[s][way] = 1; m_drt[s][way] = 0; m_tag[s][way] = t;
    end
    if (wr) begin
      m_drt[s][way] = 1;
      refv[a] = wd;
    end
    m_lru[s] = (way == 0);
    ed = wr ? wd : refv[a];
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input string rq, input bit hold, output bit got_hit);
    bit eh, ewb;
    logic [DATA_W-1:0] ed, d0, got_d;
    int wb0, rd0, we0, re0;
    model_access(wr, a, wd, eh, ewb, ed);
    wb0 = wb_beats; rd0 = rd_reqs; we0 = wb_errs; re0 = rd_errs;
    txn_rd_seen = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    if (hold) begin
      while (!rsp_valid) @(negedge clk);
      d0 = rsp_rdata;
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b1, "R9", "response held valid", int'(rsp_valid), 1);
      check(rsp_rdata == d0, "R9", "response data stable", int'(rsp_rdata), int'(d0));
      check(req_ready == 1'b0, "R9", "busy while response pending", int'(req_ready), 0);
      rsp_ready = 1'b1;
    end
    forever begin
      if (rsp_valid && rsp_ready) break;
      @(negedge clk);
      rsp_ready = (($urandom % 3) != 0);
    end
    got_d   = rsp_rdata;
    got_hit = rsp_hit;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check(got_hit == eh, rq, "hit flag", int'(got_hit), int'(eh));
    check(got_d == ed, "R6", "response data", int'(got_d), int'(ed));
    check((wb_beats - wb0) == (ewb ? WORDS : 0), "R7", "write-back beats",
          wb_beats - wb0, ewb ? WORDS : 0);
    check((rd_reqs - rd0) == (eh ? 0 : 1), "R8", "refill read requests", rd_reqs - rd0, eh ? 0 : 1);
    check(wb_errs == we0, "R7", "write-back order/data errors", wb_errs - we0, 0);
    check(rd_errs == re0, "R8", "refill request offset errors", rd_errs - re0, 0);
  endtask

  // memory side: random ready, refill beats with random gaps
  initial begin
    for (int i = 0; i < SPACE; i++) begin
      mem[i]  = init_word(i);
      refv[i] = init_word(i);
    end
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      if (rst) begin
        mem_ready = 1'b0;
      end else begin
        if (rd_left > 0 && !rd_fresh && (($urandom % 4) != 0)) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[rd_base + rd_idx];
          rd_idx++;
          rd_left--;
        end
        rd_fresh  = 0;
        mem_ready = (($urandom % 4) != 0);
        if (mem_valid && mem_ready) begin
          if (mem_write) begin
            wb_beats++;
            if (txn_rd_seen) wb_errs++;
            if (int'(mem_addr[OFF_W-1:0]) != wb_next) wb_errs++;
            if (mem_wdata != refv[mem_addr]) wb_errs++;
            wb_next = (wb_next + 1) % WORDS;
            mem[mem_addr] = mem_wdata;
          end else begin
            rd_reqs++;
            txn_rd_seen = 1;
            if (mem_addr[OFF_W-1:0] != '0) rd_errs++;
            rd_base  = int'(mem_addr);
            rd_idx   = 0;
            rd_left  = WORDS;
            rd_fresh = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit h;
    bit seq_hits [6];
    logic [ADDR_W-1:0] seq_addr [6];
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_vld[s][w] = 0; m_drt[s][w] = 0; m_tag[s][w] = '0; end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check(mem_valid == 1'b0, "R1", "mem_valid after reset", int'(mem_valid), 0);

    // R10: directed sequence {tag,set,word}
    seq_addr[0] = 6'b1000_0_0; seq_addr[1] = 6'b1000_1_1; seq_addr[2] = 6'b0101_1_0;
    seq_addr[3] = 6'b1000_0_1; seq_addr[4] = 6'b1011_1_1; seq_addr[5] = 6'b0101_1_0;
    seq_hits[0] = 0; seq_hits[1] = 0; seq_hits[2] = 0;
    seq_hits[3] = 1; seq_hits[4] = 0; seq_hits[5] = 1;
    for (int i = 0; i < 6; i++) begin
      access(1'b0, seq_addr[i], '0, (i == 0) ? "R1" : "R2", 1'b0, h);
      check(h == seq_hits[i], "R10", "sequence hit pattern", int'(h), int'(seq_hits[i]));
    end
    // R10 / R3: tag 1000 was evicted from set 1
    access(1'b0, 6'b1000_1_0, '0, "R3", 1'b0, h);
    check(h == 1'b0, "R10", "evicted tag misses", int'(h), 0);

    // R3: invalid way B of set 0 filled before any eviction
    access(1'b0, 6'b0011_0_0, '0, "R3", 1'b0, h);
    access(1'b0, 6'b1000_0_0, '0, "R3", 1'b0, h);
    check(h == 1'b1, "R3", "way A kept while B was invalid", int'(h), 1);

    // R4: touching one way steers the next victim
    access(1'b0, 6'b0011_0_1, '0, "R4", 1'b0, h);
    access(1'b0, 6'b1110_0_0, '0, "R4", 1'b0, h);
    access(1'b0, 6'b0011_0_0, '0, "R4", 1'b0, h);
    check(h == 1'b1, "R4", "recently touched way survives", int'(h), 1);

    // R7: dirty line written back on eviction
    access(1'b1, 6'b0110_1_1, 8'hA5, "R7", 1'b0, h);
    access(1'b1, 6'b0110_1_0, 8'h5A, "R7", 1'b0, h);
    access(1'b0, 6'b0001_1_0, '0, "R7", 1'b0, h);
    access(1'b0, 6'b0010_1_0, '0, "R7", 1'b0, h);
    access(1'b0, 6'b0110_1_1, '0, "R6", 1'b0, h);

    // R5: heavy set 0 traffic leaves set 1 lines in place
    for (int t = 0; t < 8; t++) access(1'b1, {4'(t), 1'b0, 1'b0}, 8'(t + 100), "R5", 1'b0, h);
    access(1'b0, 6'b0110_1_0, '0, "R5", 1'b0, h);
    check(h == 1'b1, "R5", "other set untouched", int'(h), 1);

    // R9: response held under back-pressure
    access(1'b0, 6'b0110_1_1, '0, "R9", 1'b1, h);
    access(1'b1, 6'b1111_0_1, 8'h3C, "R9", 1'b1, h);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic wr;
      a  = {4'($urandom % 6), 1'($urandom % 2), 1'($urandom % 2)};
      wr = (($urandom % 10) < 4);
      access(wr, a, 8'($urandom), "R2 R4", 1'b0, h);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule